// File: doc/BRIEF.md
# Supply Supervisor with Reset Delay and Watchdog

This block turns three digitised undervoltage flags, an active-low push-button reset and a bus-activity restart strobe into the supervisory signals of a board. The main supply flag and the push-button together drive the system reset. Once both are inactive, the reset is held for a selectable power-up delay. The main supply flag also drives an early low-supply output that has no delay. The second and third supply flags each drive their own fail output, also with no delay. A watchdog watches the restart strobe, which a serial bus decoder raises when it sees a start followed by a stop, or a complete transfer. If the strobe stays absent for the selected period, the watchdog drives a timed low pulse on its output.

A one-cycle tick input at 1 kHz sets every delay, so one tick stands for one millisecond. The parameter `TICK_DIV` divides all millisecond counts, which keeps simulation short. A value below one tick rounds up to one. The parameter `RST_ACT_HIGH` picks the polarity of the system reset output. The usual strap values are `pup_code = 01` and `wd_code = 11` (watchdog off).

Top module: `supply_supervisor`

## Requirements
- R1: While `rst` is high, and one cycle after it rises, `sys_rst` is active, `lowline_n`, `v2_fail_n` and `v3_fail_n` are low, and `wdo_n` is high.
- R2: A high `v1_low` sampled on a clock edge makes `sys_rst` active and `lowline_n` low after that same edge.
- R3: After `v1_low` and the push-button are both inactive, `sys_rst` stays active for exactly D ticks, then releases. D is 50, 200, 400 or 800 ms divided by `TICK_DIV`, for `pup_code` 00, 01, 10 or 11.
- R4: While `mr_n` is low, `sys_rst` stays active. After release, `sys_rst` stays active for the full delay D of R3.
- R5: `lowline_n` returns high one edge after `v1_low` is sampled low, with no power-up delay, so it leads `sys_rst` on release.
- R6: `v2_fail_n` and `v3_fail_n` equal the inverse of `v2_low` and `v3_low`, as sampled on the previous edge.
- R7: The watchdog period P is 1400, 200 or 25 ms divided by `TICK_DIV`, for `wd_code` 00, 01 or 10. If no restart arrives, `wdo_n` goes low P ticks after the last restart. `wd_code` 11 disables the watchdog and holds `wdo_n` high.
- R8: A `kick` pulse sampled while `wdo_n` is high sets the watchdog count to zero and starts a new full period.
- R9: A `wdo_n` low pulse lasts W ticks: 200 ms for codes 00 and 01, 25 ms for code 10, each divided by `TICK_DIV`. A new period then starts by itself.
- R10: Any change of `wd_code` ends a pulse in progress and restarts the watchdog count from zero.
- R11: Delay and watchdog counts advance only on cycles where `tick` is high.
- R12: With `RST_ACT_HIGH = 0`, `sys_rst` is the exact inverse of the active-high variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 1 kHz time base strobe |
| v1_low | input | 1 | Main supply below threshold |
| v2_low | input | 1 | Second supply below threshold |
| v3_low | input | 1 | Third supply below threshold |
| mr_n | input | 1 | Manual reset, active low |
| kick | input | 1 | Watchdog restart strobe from the bus decoder |
| pup_code | input | 2 | Power-up delay select |
| wd_code | input | 2 | Watchdog period select |
| sys_rst | output | 1 | System reset, polarity set by `RST_ACT_HIGH` |
| lowline_n | output | 1 | Early low main supply, active low |
| v2_fail_n | output | 1 | Second supply fail, active low |
| v3_fail_n | output | 1 | Third supply fail, active low |
| wdo_n | output | 1 | Watchdog timeout pulse, active low |

## Verification
Every output is registered, so a flag or push-button change shows on the outputs one edge after it is sampled. The release of `sys_rst` comes on the D-th ticking edge after the last edge that saw a hold condition. A watchdog timeout comes on the P-th ticking edge after the edge that took the restart or code change, and the pulse ends W edges later. The bench drives inputs just after a falling edge and samples at falling edges. It checks each count both one edge before its due edge and at it, so an off-by-one in either direction fails a check.

// File: rtl/sup_pkg.sv
`timescale 1ns/1ps
package sup_pkg;

    localparam int unsigned MAX_MS = 1400;

    localparam logic [1:0] WD_OFF = 2'b11;

    typedef struct packed {
        logic main;
        logic aux2;
        logic aux3;
    } uv_flags_t;

    typedef enum logic {
        WD_COUNT = 1'b0,
        WD_FIRE  = 1'b1
    } wd_state_t;

    function automatic int unsigned scale_ms(input int unsigned ms, input int unsigned div);
        int unsigned t;
        t = ms / div;
        return (t == 0) ? 1 : t;
    endfunction

    function automatic int unsigned por_ms(input logic [1:0] code);
        case (code)
            2'b00:   return 50;
            2'b01:   return 200;
            2'b10:   return 400;
            default: return 800;
        endcase
    endfunction

    function automatic int unsigned wd_period_ms(input logic [1:0] code);
        case (code)
            2'b00:   return 1400;
            2'b01:   return 200;
            2'b10:   return 25;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned wd_pulse_ms(input logic [1:0] code);
        return (code == 2'b10) ? 25 : 200;
    endfunction

endpackage

// File: rtl/sup_reset_gen.sv
`timescale 1ns/1ps
module sup_reset_gen
    import sup_pkg::*;
#(
    parameter int unsigned TICK_DIV = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       hold,
    input  logic [1:0] pup_code,
    output logic       active
);
    localparam int unsigned CW = $clog2(MAX_MS / TICK_DIV + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb lim = CW'(scale_ms(por_ms(pup_code), TICK_DIV) - 1);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active && tick) begin
            if (cnt >= lim) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sup_watchdog.sv
`timescale 1ns/1ps
module sup_watchdog
    import sup_pkg::*;
#(
    parameter int unsigned TICK_DIV = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       kick,
    input  logic [1:0] wd_code,
    output logic       wdo_n
);
    localparam int unsigned CW = $clog2(MAX_MS / TICK_DIV + 1);

    wd_state_t     st;
    logic [1:0]    last_code;
    logic [CW-1:0] cnt;
    logic [CW-1:0] per_lim;
    logic [CW-1:0] pul_lim;
    logic          restart;

    always_comb begin
        per_lim = CW'(scale_ms(wd_period_ms(wd_code), TICK_DIV) - 1);
        pul_lim = CW'(scale_ms(wd_pulse_ms(wd_code), TICK_DIV) - 1);
        restart = (wd_code != last_code) || (wd_code == WD_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= WD_COUNT;
            cnt       <= '0;
            last_code <= wd_code;
        end else begin
            last_code <= wd_code;
            if (restart) begin
                st  <= WD_COUNT;
                cnt <= '0;
            end else if (st == WD_COUNT) begin
                if (kick) begin
                    cnt <= '0;
                end else if (tick) begin
                    if (cnt >= per_lim) begin
                        st  <= WD_FIRE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end else if (tick) begin
                if (cnt >= pul_lim) begin
                    st  <= WD_COUNT;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign wdo_n = (st != WD_FIRE);
endmodule

// File: rtl/supply_supervisor.sv
`timescale 1ns/1ps
module supply_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned TICK_DIV     = 1,
    parameter bit          RST_ACT_HIGH = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       v1_low,
    input  logic       v2_low,
    input  logic       v3_low,
    input  logic       mr_n,
    input  logic       kick,
    input  logic [1:0] pup_code,
    input  logic [1:0] wd_code,
    output logic       sys_rst,
    output logic       lowline_n,
    output logic       v2_fail_n,
    output logic       v3_fail_n,
    output logic       wdo_n
);
    uv_flags_t uv;
    uv_flags_t good_q;
    logic      rst_active;

    assign uv = '{main: v1_low, aux2: v2_low, aux3: v3_low};

    always_ff @(posedge clk) begin
        if (rst) good_q <= '0;
        else     good_q <= ~uv;
    end

    assign lowline_n = good_q.main;
    assign v2_fail_n = good_q.aux2;
    assign v3_fail_n = good_q.aux3;

    sup_reset_gen #(.TICK_DIV(TICK_DIV)) u_rstgen (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .hold     (v1_low | ~mr_n),
        .pup_code (pup_code),
        .active   (rst_active)
    );

    sup_watchdog #(.TICK_DIV(TICK_DIV)) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .kick    (kick),
        .wd_code (wd_code),
        .wdo_n   (wdo_n)
    );

    generate
        if (RST_ACT_HIGH) begin : g_rst_hi
            assign sys_rst = rst_active;
        end else begin : g_rst_lo
            assign sys_rst = ~rst_active;
        end
    endgenerate
endmodule

// File: rtl/supply_supervisor_chk.sv
`timescale 1ns/1ps
module supply_supervisor_chk #(
    parameter bit ACT_HIGH = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       v1_low,
    input logic       v2_low,
    input logic       v3_low,
    input logic       mr_n,
    input logic       kick,
    input logic [1:0] wd_code,
    input logic       sys_rst,
    input logic       lowline_n,
    input logic       v2_fail_n,
    input logic       v3_fail_n,
    input logic       wdo_n
);
    logic rst_on;
    assign rst_on = ACT_HIGH ? sys_rst : ~sys_rst;

    p_in_reset_r1: assert property (@(posedge clk) rst |=> rst_on && !lowline_n && wdo_n);

    p_low_asserts_r2: assert property (@(posedge clk) disable iff (rst)
        v1_low |=> rst_on && !lowline_n);

    p_release_good_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_on) |-> lowline_n);

    p_button_holds_r4: assert property (@(posedge clk) disable iff (rst)
        !mr_n |=> rst_on);

    p_fail2_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (v2_fail_n == !$past(v2_low)));

    p_fail3_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (v3_fail_n == !$past(v3_low)));

    p_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (wd_code == 2'b11) |=> wdo_n);

    p_kick_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (kick && wdo_n) |=> wdo_n);
endmodule

bind supply_supervisor supply_supervisor_chk #(.ACT_HIGH(RST_ACT_HIGH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .v1_low    (v1_low),
    .v2_low    (v2_low),
    .v3_low    (v3_low),
    .mr_n      (mr_n),
    .kick      (kick),
    .wd_code   (wd_code),
    .sys_rst   (sys_rst),
    .lowline_n (lowline_n),
    .v2_fail_n (v2_fail_n),
    .v3_fail_n (v3_fail_n),
    .wdo_n     (wdo_n)
);

// File: tb/supply_supervisor_bench.sv
`timescale 1ns/1ps
module supply_supervisor_bench;
    localparam int unsigned DIV = 5;

    logic clk = 1'b0;
    logic rst, tick, v1_low, v2_low, v3_low, mr_n, kick;
    logic [1:0] pup_code, wd_code;
    logic sys_rst, lowline_n, v2_fail_n, v3_fail_n, wdo_n;
    logic sys_rst_lo, lowline_n_lo, v2_fail_n_lo, v3_fail_n_lo, wdo_n_lo;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    supply_supervisor #(.TICK_DIV(DIV), .RST_ACT_HIGH(1'b1)) u_supply_supervisor (
        .clk(clk), .rst(rst), .tick(tick), .v1_low(v1_low), .v2_low(v2_low),
        .v3_low(v3_low), .mr_n(mr_n), .kick(kick), .pup_code(pup_code),
        .wd_code(wd_code), .sys_rst(sys_rst), .lowline_n(lowline_n),
        .v2_fail_n(v2_fail_n), .v3_fail_n(v3_fail_n), .wdo_n(wdo_n));

    supply_supervisor #(.TICK_DIV(DIV), .RST_ACT_HIGH(1'b0)) u_supply_supervisor_lo (
        .clk(clk), .rst(rst), .tick(tick), .v1_low(v1_low), .v2_low(v2_low),
        .v3_low(v3_low), .mr_n(mr_n), .kick(kick), .pup_code(pup_code),
        .wd_code(wd_code), .sys_rst(sys_rst_lo), .lowline_n(lowline_n_lo),
        .v2_fail_n(v2_fail_n_lo), .v3_fail_n(v3_fail_n_lo), .wdo_n(wdo_n_lo));

    function automatic int por_ticks(input logic [1:0] c);
        int ms;
        ms = (c == 2'b00) ? 50 : (c == 2'b01) ? 200 : (c == 2'b10) ? 400 : 800;
        return ms / DIV;
    endfunction

    function automatic int per_ticks(input logic [1:0] c);
        return ((c == 2'b00) ? 1400 : (c == 2'b01) ? 200 : 25) / DIV;
    endfunction

    function automatic int pulse_ticks(input logic [1:0] c);
        return ((c == 2'b10) ? 25 : 200) / DIV;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        rst = 1'b1; tick = 1'b1; v1_low = 1'b0; v2_low = 1'b0; v3_low = 1'b0;
        mr_n = 1'b1; kick = 1'b0; pup_code = 2'b01; wd_code = 2'b11;
        step(3);
        // R1 reset state, R12 polarity
        chk("R1 sys_rst", sys_rst, 1'b1);
        chk("R1 lowline_n", lowline_n, 1'b0);
        chk("R1 v2_fail_n", v2_fail_n, 1'b0);
        chk("R1 v3_fail_n", v3_fail_n, 1'b0);
        chk("R1 wdo_n", wdo_n, 1'b1);
        chk("R12 inverted", sys_rst_lo, 1'b0);
        rst = 1'b0;
        step(1);
        chk("R5 lowline up", lowline_n, 1'b1);
        step(por_ticks(2'b01) - 2);
        chk("R3 powerup hold", sys_rst, 1'b1);
        step(1);
        chk("R3 powerup release", sys_rst, 1'b0);
        chk("R12 released", sys_rst_lo, 1'b1);

        // R2 R3 R5 over every delay code
        for (int c = 0; c < 4; c++) begin
            pup_code = 2'(c);
            v1_low = 1'b1;
            step(1);
            chk("R2 rst", sys_rst, 1'b1);
            chk("R2 lowline", lowline_n, 1'b0);
            chk("R12 active", sys_rst_lo, 1'b0);
            v1_low = 1'b0;
            step(1);
            chk("R5 no delay", lowline_n, 1'b1);
            chk("R5 rst still", sys_rst, 1'b1);
            step(por_ticks(2'(c)) - 2);
            chk("R3 hold", sys_rst, 1'b1);
            step(1);
            chk("R3 release", sys_rst, 1'b0);
        end

        // R11 no tick, no progress
        pup_code = 2'b00;
        tick = 1'b0;
        v1_low = 1'b1; step(1); v1_low = 1'b0;
        step(200);
        chk("R11 frozen", sys_rst, 1'b1);
        tick = 1'b1;
        step(por_ticks(2'b00) - 1);
        chk("R11 resume hold", sys_rst, 1'b1);
        step(1);
        chk("R11 resume release", sys_rst, 1'b0);

        // R4 manual reset
        mr_n = 1'b0;
        step(1);
        chk("R4 press", sys_rst, 1'b1);
        step(30);
        chk("R4 held", sys_rst, 1'b1);
        mr_n = 1'b1;
        step(por_ticks(2'b00) - 1);
        chk("R4 after release", sys_rst, 1'b1);
        step(1);
        chk("R4 release", sys_rst, 1'b0);

        // R6 all flag patterns
        for (int p = 0; p < 4; p++) begin
            v2_low = p[0]; v3_low = p[1];
            step(1);
            chk("R6 v2", v2_fail_n, ~p[0]);
            chk("R6 v3", v3_fail_n, ~p[1]);
        end
        v2_low = 1'b0; v3_low = 1'b0;

        // R7 R9 over every period code
        for (int c = 2; c >= 0; c--) begin
            wd_code = 2'(c);
            step(per_ticks(2'(c)));
            chk("R7 before timeout", wdo_n, 1'b1);
            step(1);
            chk("R7 timeout", wdo_n, 1'b0);
            step(pulse_ticks(2'(c)) - 1);
            chk("R9 pulse held", wdo_n, 1'b0);
            step(1);
            chk("R9 pulse end", wdo_n, 1'b1);
            step(per_ticks(2'(c)) - 1);
            chk("R9 rerun high", wdo_n, 1'b1);
            step(1);
            chk("R9 rerun timeout", wdo_n, 1'b0);
            wd_code = 2'b11;
            step(1);
            chk("R10 code change ends pulse", wdo_n, 1'b1);
        end

        // R8 kick
        wd_code = 2'b01;
        step(30);
        kick = 1'b1; step(1); kick = 1'b0;
        step(per_ticks(2'b01) - 1);
        chk("R8 kick delays", wdo_n, 1'b1);
        step(1);
        chk("R8 timeout after kick", wdo_n, 1'b0);

        // R10 code change restarts count
        wd_code = 2'b11; step(1);
        wd_code = 2'b01; step(30);
        wd_code = 2'b10;
        step(per_ticks(2'b10));
        chk("R10 restart", wdo_n, 1'b1);
        step(1);
        chk("R10 timeout", wdo_n, 1'b0);

        // R7 disabled
        wd_code = 2'b11;
        step(400);
        chk("R7 disabled", wdo_n, 1'b1);

        // R1 mid-run reset
        v2_low = 1'b0;
        rst = 1'b1;
        step(1);
        chk("R1 mid sys_rst", sys_rst, 1'b1);
        chk("R1 mid lowline_n", lowline_n, 1'b0);
        chk("R1 mid v2", v2_fail_n, 1'b0);
        rst = 1'b0;
        step(1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end
endmodule